// File: doc/BRIEF.md
# Display Background and Picture Window Compositor

This block runs in the display pixel clock domain and decides, pixel by pixel, what the video output shows. It follows the display line and field sync pulses and keeps a pixel count since the last line sync and a line count since the last field sync. From these counts and a set of configuration inputs it places one rectangle of flat background colour and two picture windows: one for the main channel and one for the sub channel. For each pixel it selects live pass-through video, the background colour, or stored pixels of one of the windows. It also drives a fast-blanking control and a read request per window toward pixel storage.

All configuration inputs are copied into a shadow set on each field sync edge and used only from there, so a mid-field change never splits a picture. A small field state machine controls composition. NOSYNC is entered at reset and holds until the first field sync. ACTIVE is entered from any state on a field sync. HOLD is entered from ACTIVE when a line sync arrives after the line count has already reached `MAX_LINES`, and it lasts until the next field sync. Composition happens only in ACTIVE. In NOSYNC and HOLD the output is live video with all requests low.

Top module: `pipc_compositor`

## Requirements
- R1: After reset, and in the NOSYNC state before the first field sync edge, `src_o` is 0 (live), and `fblank_o`, `rd_main_o`, `rd_sub_o`, `bg_col_o` and `bg_lvl_o` are all zero, whatever the configuration inputs hold.
- R2: The pixel count x is the number of clocks since the last line sync rising edge, starting at 0. The line count y is the number of line sync rising edges since the last field sync rising edge. The outputs for pixel x appear two clocks after the line sync edge is sampled. The background covers x from `H_BASE`+`bg_hoff_i` for `BG_W` pixels, and y from `V_BASE`+`bg_voff_i` for `NTSC_H` lines when `pal_i`=0, or `PAL_H` lines when `pal_i`=1.
- R3: Every configuration input is sampled only on the clock that sees a field sync rising edge. A change at any other time has no effect until the next field sync.
- R4: The origin of each window is the background origin plus that window's 8-bit horizontal and vertical offsets. Its width is `BG_W`/f and its height is (background height)/f, with integer truncation. The factor f is the 2-bit reduction code plus 1, chosen separately per axis and per window.
- R5: When `src_o` is 1, `bg_col_o` equals the colour code and `bg_lvl_o` equals the brightness level of full scale 2^`LVL_W`-1, truncated: code 0 gives 30 %, code 1 gives 50 %, code 2 gives 70 % and code 3 gives 100 %. For any other source both outputs are zero.
- R6: The source code is 0 for live, 1 for background, 2 for main window and 3 for sub window. When regions overlap, sub has priority over main, main over background, and background over live.
- R7: `fblank_o` is high exactly when `src_o` is non-zero.
- R8: `rd_main_o` (or `rd_sub_o`) is high whenever that window is enabled and covers the pixel in ACTIVE, even where a window of higher priority hides it.
- R9: Once y equals `MAX_LINES`, a further line sync with no field sync moves the block to HOLD. In HOLD the output is live with all requests low. The next field sync resumes composition.
- R10: The background enable works separately from the window enables. A window is shown over live video when the background is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dhs_i | input | 1 | Display line sync; a rising edge starts a line |
| dvs_i | input | 1 | Display field sync; a rising edge starts a field |
| pal_i | input | 1 | Standard select: 1 selects the taller background |
| bg_en_i | input | 1 | Background enable |
| main_en_i | input | 1 | Main window enable |
| sub_en_i | input | 1 | Sub window enable |
| bg_col_i | input | 3 | Background colour code |
| bg_brt_i | input | 2 | Background brightness code |
| bg_hoff_i | input | 8 | Background horizontal fine offset |
| bg_voff_i | input | 8 | Background vertical fine offset |
| main_hoff_i | input | 8 | Main window horizontal offset from the background origin |
| main_voff_i | input | 8 | Main window vertical offset from the background origin |
| sub_hoff_i | input | 8 | Sub window horizontal offset from the background origin |
| sub_voff_i | input | 8 | Sub window vertical offset from the background origin |
| main_hred_i | input | 2 | Main window horizontal reduction code |
| main_vred_i | input | 2 | Main window vertical reduction code |
| sub_hred_i | input | 2 | Sub window horizontal reduction code |
| sub_vred_i | input | 2 | Sub window vertical reduction code |
| src_o | output | 2 | Selected source for the pixel |
| fblank_o | output | 1 | Fast-blanking control |
| bg_col_o | output | 3 | Background colour code while the background is selected |
| bg_lvl_o | output | LVL_W | Background brightness level while the background is selected |
| rd_main_o | output | 1 | Read request for main window pixel storage |
| rd_sub_o | output | 1 | Read request for sub window pixel storage |

## Verification
The bench compares every pixel of many scanned lines against its own model of the rectangles. This catches an off-by-one at any window edge, a swapped overlap priority that would show main pixels inside the sub window, and a division-by-three factor that would give the wrong width. Read requests are checked under overlap: a design that gated them with the priority would drop main requests under the sub window. A configuration change made mid-field must leave the rest of that field unchanged, so a design without shadowing would tear. A long field with no field sync must go live after `MAX_LINES` lines and recover on the next field sync, so a missing HOLD state would keep drawing. Writes made before the first field sync must not produce a picture.

// File: rtl/pipc_pkg.sv
package pipc_pkg;

    localparam int OFF_W = 8;
    localparam int NWIN  = 2;
    localparam int WIN_MAIN = 0;
    localparam int WIN_SUB  = 1;

    typedef enum logic [1:0] {
        SRC_LIVE = 2'd0,
        SRC_BG   = 2'd1,
        SRC_MAIN = 2'd2,
        SRC_SUB  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        FS_NOSYNC = 2'd0,
        FS_ACTIVE = 2'd1,
        FS_HOLD   = 2'd2
    } fstate_e;

    typedef struct packed {
        logic                       pal;
        logic                       bg_en;
        logic [2:0]                 bg_col;
        logic [1:0]                 bg_brt;
        logic [OFF_W-1:0]           bg_hoff;
        logic [OFF_W-1:0]           bg_voff;
        logic [NWIN-1:0]            win_en;
        logic [NWIN-1:0][OFF_W-1:0] win_hoff;
        logic [NWIN-1:0][OFF_W-1:0] win_voff;
        logic [NWIN-1:0][1:0]       win_hred;
        logic [NWIN-1:0][1:0]       win_vred;
    } cfg_t;

endpackage

// File: rtl/pipc_shadow.sv
module pipc_shadow
    import pipc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  cfg_t cfg_i,
    output cfg_t cfg_o
);

    // Configuration is copied only at a field start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (load_i) begin
            cfg_o <= cfg_i;
        end
    end

endmodule

// File: rtl/pipc_raster.sv
module pipc_raster
    import pipc_pkg::*;
#(
    parameter int CW        = 12,
    parameter int MAX_LINES = 320
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_i,
    input  logic          vs_i,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output fstate_e       state_o,
    output logic          field_start_o
);

    localparam logic [CW-1:0] X_SAT  = {CW{1'b1}};
    localparam logic [CW-1:0] Y_LAST = CW'(MAX_LINES);

    logic    hs_q, vs_q;
    logic    hs_edge, vs_edge;
    fstate_e st_q, st_d;

    assign hs_edge       = hs_i & ~hs_q;
    assign vs_edge       = vs_i & ~vs_q;
    assign field_start_o = vs_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hs_i;
            vs_q <= vs_i;
        end
    end

    // Field state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FS_NOSYNC;
        end else begin
            st_q <= st_d;
        end
    end

    // Field state transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_NOSYNC: if (vs_edge) st_d = FS_ACTIVE;
            FS_ACTIVE: begin
                if (vs_edge) begin
                    st_d = FS_ACTIVE;
                end else if (hs_edge && (y_o == Y_LAST)) begin
                    st_d = FS_HOLD;
                end
            end
            FS_HOLD:   if (vs_edge) st_d = FS_ACTIVE;
            default:   st_d = FS_NOSYNC;
        endcase
    end

    // Raster position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
        end else begin
            if (vs_edge || hs_edge) begin
                x_o <= '0;
            end else if (x_o != X_SAT) begin
                x_o <= x_o + 1'b1;
            end
            if (vs_edge) begin
                y_o <= '0;
            end else if (hs_edge && (st_q != FS_HOLD) && (y_o != Y_LAST)) begin
                y_o <= y_o + 1'b1;
            end
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/pipc_rect.sv
module pipc_rect #(
    parameter int CW = 12
) (
    input  logic          en_i,
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    input  logic [CW-1:0] x0_i,
    input  logic [CW-1:0] y0_i,
    input  logic [CW-1:0] w_i,
    input  logic [CW-1:0] h_i,
    output logic          hit_o
);

    logic [CW:0] x_end, y_end;
    logic        in_x, in_y;

    always_comb begin
        x_end = {1'b0, x0_i} + {1'b0, w_i};
        y_end = {1'b0, y0_i} + {1'b0, h_i};
        in_x  = (x_i >= x0_i) && ({1'b0, x_i} < x_end);
        in_y  = (y_i >= y0_i) && ({1'b0, y_i} < y_end);
        hit_o = en_i && in_x && in_y;
    end

endmodule

// File: rtl/pipc_compositor.sv
module pipc_compositor
    import pipc_pkg::*;
#(
    parameter int BG_W      = 696,
    parameter int NTSC_H    = 238,
    parameter int PAL_H     = 286,
    parameter int H_BASE    = 140,
    parameter int V_BASE    = 22,
    parameter int MAX_LINES = 320,
    parameter int LVL_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dhs_i,
    input  logic             dvs_i,
    input  logic             pal_i,
    input  logic             bg_en_i,
    input  logic             main_en_i,
    input  logic             sub_en_i,
    input  logic [2:0]       bg_col_i,
    input  logic [1:0]       bg_brt_i,
    input  logic [7:0]       bg_hoff_i,
    input  logic [7:0]       bg_voff_i,
    input  logic [7:0]       main_hoff_i,
    input  logic [7:0]       main_voff_i,
    input  logic [7:0]       sub_hoff_i,
    input  logic [7:0]       sub_voff_i,
    input  logic [1:0]       main_hred_i,
    input  logic [1:0]       main_vred_i,
    input  logic [1:0]       sub_hred_i,
    input  logic [1:0]       sub_vred_i,
    output logic [1:0]       src_o,
    output logic             fblank_o,
    output logic [2:0]       bg_col_o,
    output logic [LVL_W-1:0] bg_lvl_o,
    output logic             rd_main_o,
    output logic             rd_sub_o
);

    localparam int OFF_MAX = (1 << OFF_W) - 1;
    localparam int TALL_H  = (PAL_H > NTSC_H) ? PAL_H : NTSC_H;
    localparam int X_SPAN  = H_BASE + 2 * OFF_MAX + BG_W;
    localparam int Y_SPAN  = V_BASE + 2 * OFF_MAX + TALL_H;
    localparam int XY_SPAN = (X_SPAN > Y_SPAN) ? X_SPAN : Y_SPAN;
    localparam int SPAN    = (XY_SPAN > MAX_LINES) ? XY_SPAN : MAX_LINES;
    localparam int CW      = $clog2(SPAN + 1) + 1;
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    localparam logic [CW-1:0] W_TAB [4] = '{
        CW'(BG_W), CW'(BG_W / 2), CW'(BG_W / 3), CW'(BG_W / 4)
    };
    localparam logic [CW-1:0] HN_TAB [4] = '{
        CW'(NTSC_H), CW'(NTSC_H / 2), CW'(NTSC_H / 3), CW'(NTSC_H / 4)
    };
    localparam logic [CW-1:0] HP_TAB [4] = '{
        CW'(PAL_H), CW'(PAL_H / 2), CW'(PAL_H / 3), CW'(PAL_H / 4)
    };
    localparam logic [LVL_W-1:0] LVL_TAB [4] = '{
        LVL_W'(LVL_MAX * 30 / 100), LVL_W'(LVL_MAX * 50 / 100),
        LVL_W'(LVL_MAX * 70 / 100), LVL_W'(LVL_MAX)
    };

    cfg_t          cfg_in, cfg_q;
    logic [CW-1:0] px, ln;
    fstate_e       fstate;
    logic          field_start;

    always_comb begin
        cfg_in                    = '0;
        cfg_in.pal                = pal_i;
        cfg_in.bg_en              = bg_en_i;
        cfg_in.bg_col             = bg_col_i;
        cfg_in.bg_brt             = bg_brt_i;
        cfg_in.bg_hoff            = bg_hoff_i;
        cfg_in.bg_voff            = bg_voff_i;
        cfg_in.win_en[WIN_MAIN]   = main_en_i;
        cfg_in.win_en[WIN_SUB]    = sub_en_i;
        cfg_in.win_hoff[WIN_MAIN] = main_hoff_i;
        cfg_in.win_voff[WIN_MAIN] = main_voff_i;
        cfg_in.win_hoff[WIN_SUB]  = sub_hoff_i;
        cfg_in.win_voff[WIN_SUB]  = sub_voff_i;
        cfg_in.win_hred[WIN_MAIN] = main_hred_i;
        cfg_in.win_vred[WIN_MAIN] = main_vred_i;
        cfg_in.win_hred[WIN_SUB]  = sub_hred_i;
        cfg_in.win_vred[WIN_SUB]  = sub_vred_i;
    end

    pipc_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (field_start),
        .cfg_i  (cfg_in),
        .cfg_o  (cfg_q)
    );

    pipc_raster #(
        .CW        (CW),
        .MAX_LINES (MAX_LINES)
    ) u_raster (
        .clk           (clk),
        .rst_n         (rst_n),
        .hs_i          (dhs_i),
        .vs_i          (dvs_i),
        .x_o           (px),
        .y_o           (ln),
        .state_o       (fstate),
        .field_start_o (field_start)
    );

    // Background rectangle
    logic [CW-1:0] bg_x0, bg_y0, bg_h;
    logic          hit_bg;

    always_comb begin
        bg_x0 = CW'(H_BASE) + CW'(cfg_q.bg_hoff);
        bg_y0 = CW'(V_BASE) + CW'(cfg_q.bg_voff);
        bg_h  = cfg_q.pal ? CW'(PAL_H) : CW'(NTSC_H);
    end

    pipc_rect #(.CW(CW)) u_bg_rect (
        .en_i  (cfg_q.bg_en),
        .x_i   (px),
        .y_i   (ln),
        .x0_i  (bg_x0),
        .y0_i  (bg_y0),
        .w_i   (CW'(BG_W)),
        .h_i   (bg_h),
        .hit_o (hit_bg)
    );

    // Picture windows, placed relative to the background origin
    logic [NWIN-1:0] hit_win;

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            logic [CW-1:0] wx0, wy0, ww, wh;
            always_comb begin
                wx0 = bg_x0 + CW'(cfg_q.win_hoff[w]);
                wy0 = bg_y0 + CW'(cfg_q.win_voff[w]);
                ww  = W_TAB[cfg_q.win_hred[w]];
                wh  = cfg_q.pal ? HP_TAB[cfg_q.win_vred[w]]
                                : HN_TAB[cfg_q.win_vred[w]];
            end
            pipc_rect #(.CW(CW)) u_win_rect (
                .en_i  (cfg_q.win_en[w]),
                .x_i   (px),
                .y_i   (ln),
                .x0_i  (wx0),
                .y0_i  (wy0),
                .w_i   (ww),
                .h_i   (wh),
                .hit_o (hit_win[w])
            );
        end
    endgenerate

    // Overlap priority: sub, main, background, live
    src_e src_sel;

    always_comb begin
        if (hit_win[WIN_SUB]) begin
            src_sel = SRC_SUB;
        end else if (hit_win[WIN_MAIN]) begin
            src_sel = SRC_MAIN;
        end else if (hit_bg) begin
            src_sel = SRC_BG;
        end else begin
            src_sel = SRC_LIVE;
        end
    end

    // Output register, driven by the field state
    src_e             src_q;
    logic             fb_q, rdm_q, rds_q;
    logic [2:0]       col_q;
    logic [LVL_W-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_LIVE;
            fb_q  <= 1'b0;
            col_q <= '0;
            lvl_q <= '0;
            rdm_q <= 1'b0;
            rds_q <= 1'b0;
        end else begin
            unique case (fstate)
                FS_ACTIVE: begin
                    src_q <= src_sel;
                    fb_q  <= (src_sel != SRC_LIVE);
                    col_q <= (src_sel == SRC_BG) ? cfg_q.bg_col : 3'd0;
                    lvl_q <= (src_sel == SRC_BG) ? LVL_TAB[cfg_q.bg_brt] : '0;
                    rdm_q <= hit_win[WIN_MAIN];
                    rds_q <= hit_win[WIN_SUB];
                end
                default: begin
                    src_q <= SRC_LIVE;
                    fb_q  <= 1'b0;
                    col_q <= '0;
                    lvl_q <= '0;
                    rdm_q <= 1'b0;
                    rds_q <= 1'b0;
                end
            endcase
        end
    end

    assign src_o     = src_q;
    assign fblank_o  = fb_q;
    assign bg_col_o  = col_q;
    assign bg_lvl_o  = lvl_q;
    assign rd_main_o = rdm_q;
    assign rd_sub_o  = rds_q;

endmodule

// File: rtl/pipc_compositor_chk.sv
module pipc_compositor_chk
    import pipc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       src_o,
    input logic             fblank_o,
    input logic [2:0]       bg_col_o,
    input logic [LVL_W-1:0] bg_lvl_o,
    input logic             rd_main_o,
    input logic             rd_sub_o,
    input logic [1:0]       fstate,
    input logic             field_start,
    input cfg_t             cfg_q
);

    localparam int FULL = (1 << LVL_W) - 1;

    p_fb_follows_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fblank_o == (src_o != 2'd0));

    p_sub_shown_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_o == 2'd3) |-> rd_sub_o);

    p_main_shown_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_o == 2'd2) |-> (rd_main_o && !rd_sub_o));

    p_colour_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_o != 2'd1) |-> (bg_col_o == 3'd0 && bg_lvl_o == '0));

    p_level_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_o == 2'd1) |-> (bg_lvl_o == LVL_W'(FULL * 30 / 100) ||
                             bg_lvl_o == LVL_W'(FULL * 50 / 100) ||
                             bg_lvl_o == LVL_W'(FULL * 70 / 100) ||
                             bg_lvl_o == LVL_W'(FULL)));

    p_shadow_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(cfg_q));

    p_nosync_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fstate == FS_NOSYNC) |=> (src_o == 2'd0 && !rd_main_o && !rd_sub_o));

    p_hold_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fstate == FS_HOLD) |=> (src_o == 2'd0 && !rd_main_o && !rd_sub_o));

endmodule

bind pipc_compositor pipc_compositor_chk #(.LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_o       (src_o),
    .fblank_o    (fblank_o),
    .bg_col_o    (bg_col_o),
    .bg_lvl_o    (bg_lvl_o),
    .rd_main_o   (rd_main_o),
    .rd_sub_o    (rd_sub_o),
    .fstate      (fstate),
    .field_start (field_start),
    .cfg_q       (cfg_q)
);

// File: tb/tb_pipc_compositor.sv
`timescale 1ns/1ps
module tb_pipc_compositor;

    localparam int T_BGW  = 24;
    localparam int T_NH   = 6;
    localparam int T_PH   = 9;
    localparam int T_HB   = 2;
    localparam int T_VB   = 1;
    localparam int T_MAXL = 40;
    localparam int XS     = 64;

    typedef struct packed {
        logic        pal;
        logic        bg;
        logic        me;
        logic        se;
        logic [2:0]  col;
        logic [1:0]  brt;
        logic [7:0]  bgh;
        logic [7:0]  bgv;
        logic [7:0]  mh;
        logic [7:0]  mv;
        logic [7:0]  sh;
        logic [7:0]  sv;
        logic [1:0]  mhr;
        logic [1:0]  mvr;
        logic [1:0]  shr;
        logic [1:0]  svr;
        logic [15:0] exp_sub;
    } tcfg_t;

    // stimulus configurations with the expected number of sub-window pixels
    localparam tcfg_t VEC [6] = '{
        '{1'b0,1'b1,1'b1,1'b1,3'd5,2'd0,8'd3, 8'd2,8'd4,8'd1,8'd10,8'd2, 2'd1,2'd1,2'd2,2'd2,16'd16},
        '{1'b1,1'b0,1'b1,1'b1,3'd2,2'd3,8'd10,8'd0,8'd0,8'd0,8'd30,8'd5, 2'd0,2'd0,2'd3,2'd3,16'd12},
        '{1'b0,1'b1,1'b0,1'b0,3'd7,2'd2,8'd20,8'd4,8'd0,8'd0,8'd0, 8'd0, 2'd0,2'd0,2'd0,2'd0,16'd0},
        '{1'b1,1'b1,1'b1,1'b1,3'd1,2'd1,8'd0, 8'd0,8'd5,8'd3,8'd6, 8'd4, 2'd2,2'd2,2'd2,2'd1,16'd32},
        '{1'b0,1'b0,1'b0,1'b1,3'd0,2'd0,8'd0, 8'd0,8'd0,8'd0,8'd4, 8'd10,2'd0,2'd0,2'd0,2'd0,16'd144},
        '{1'b1,1'b0,1'b0,1'b0,3'd3,2'd3,8'd50,8'd9,8'd7,8'd7,8'd7, 8'd7, 2'd1,2'd1,2'd1,2'd1,16'd0}
    };

    localparam tcfg_t HOLD_CFG =
        '{1'b0,1'b1,1'b0,1'b0,3'd4,2'd3,8'd0,8'd36,8'd0,8'd0,8'd0,8'd0,2'd0,2'd0,2'd0,2'd0,16'd0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dhs = 1'b0, dvs = 1'b0;
    logic       pal = 1'b0, bg_en = 1'b0, main_en = 1'b0, sub_en = 1'b0;
    logic [2:0] bg_col = '0;
    logic [1:0] bg_brt = '0;
    logic [7:0] bg_hoff = '0, bg_voff = '0;
    logic [7:0] main_hoff = '0, main_voff = '0, sub_hoff = '0, sub_voff = '0;
    logic [1:0] main_hred = '0, main_vred = '0, sub_hred = '0, sub_vred = '0;
    logic [1:0] src;
    logic       fblank, rd_main, rd_sub;
    logic [2:0] col_o;
    logic [7:0] lvl_o;

    int n_chk = 0;
    int n_fail = 0;
    int sub_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pipc_compositor #(
        .BG_W(T_BGW), .NTSC_H(T_NH), .PAL_H(T_PH), .H_BASE(T_HB),
        .V_BASE(T_VB), .MAX_LINES(T_MAXL), .LVL_W(8)
    ) dut (
        .clk(clk), .rst_n(rst_n), .dhs_i(dhs), .dvs_i(dvs), .pal_i(pal),
        .bg_en_i(bg_en), .main_en_i(main_en), .sub_en_i(sub_en),
        .bg_col_i(bg_col), .bg_brt_i(bg_brt), .bg_hoff_i(bg_hoff), .bg_voff_i(bg_voff),
        .main_hoff_i(main_hoff), .main_voff_i(main_voff),
        .sub_hoff_i(sub_hoff), .sub_voff_i(sub_voff),
        .main_hred_i(main_hred), .main_vred_i(main_vred),
        .sub_hred_i(sub_hred), .sub_vred_i(sub_vred),
        .src_o(src), .fblank_o(fblank), .bg_col_o(col_o), .bg_lvl_o(lvl_o),
        .rd_main_o(rd_main), .rd_sub_o(rd_sub)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic apply(input tcfg_t c);
        @(negedge clk);
        pal = c.pal; bg_en = c.bg; main_en = c.me; sub_en = c.se;
        bg_col = c.col; bg_brt = c.brt; bg_hoff = c.bgh; bg_voff = c.bgv;
        main_hoff = c.mh; main_voff = c.mv; sub_hoff = c.sh; sub_voff = c.sv;
        main_hred = c.mhr; main_vred = c.mvr; sub_hred = c.shr; sub_vred = c.svr;
    endtask

    task automatic field_sync();
        @(negedge clk) dvs = 1'b1;
        @(posedge clk);
        @(negedge clk) dvs = 1'b0;
    endtask

    function automatic bit inside_rect(int x, int y, int x0, int y0, int w, int h);
        return (x >= x0) && (x < x0 + w) && (y >= y0) && (y < y0 + h);
    endfunction

    function automatic int lvl_of(logic [1:0] b);
        case (b)
            2'd0: return 76;
            2'd1: return 127;
            2'd2: return 178;
            default: return 255;
        endcase
    endfunction

    // scan lines l0..l1 of a field, comparing each pixel with the model of c
    task automatic scan(input tcfg_t c, input int l0, input int l1, input bit live);
        int bx0, by0, bh, e_src, e_rm, e_rs;
        bit hb, hm, hs;
        bx0 = T_HB + int'(c.bgh);
        by0 = T_VB + int'(c.bgv);
        bh  = c.pal ? T_PH : T_NH;
        for (int ln = l0; ln <= l1; ln++) begin
            @(negedge clk) dhs = 1'b1;
            @(posedge clk);
            @(negedge clk) dhs = 1'b0;
            @(posedge clk);
            for (int px = 0; px < XS; px++) begin
                @(negedge clk);
                hb = c.bg && inside_rect(px, ln, bx0, by0, T_BGW, bh);
                hm = c.me && inside_rect(px, ln, bx0 + int'(c.mh), by0 + int'(c.mv),
                                         T_BGW / (int'(c.mhr) + 1), bh / (int'(c.mvr) + 1));
                hs = c.se && inside_rect(px, ln, bx0 + int'(c.sh), by0 + int'(c.sv),
                                         T_BGW / (int'(c.shr) + 1), bh / (int'(c.svr) + 1));
                if (live || ln > T_MAXL) begin
                    hb = 1'b0; hm = 1'b0; hs = 1'b0;
                end
                e_src = hs ? 3 : hm ? 2 : hb ? 1 : 0;
                e_rm  = hm;
                e_rs  = hs;
                if (src == 2'd3) sub_seen++;
                chk($sformatf("R2 R4 R6 R9 R10 source at x=%0d y=%0d", px, ln), int'(src), e_src);
                chk($sformatf("R7 fast blank at x=%0d y=%0d", px, ln), int'(fblank), int'(e_src != 0));
                chk($sformatf("R8 read requests at x=%0d y=%0d", px, ln),
                    int'({rd_main, rd_sub}), (e_rm << 1) | e_rs);
                chk($sformatf("R5 colour at x=%0d y=%0d", px, ln),
                    int'({col_o, lvl_o}),
                    (e_src == 1) ? ((int'(c.col) << 8) | lvl_of(c.brt)) : 0);
                @(posedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset source", int'(src), 0);
        chk("R1 reset fast blank", int'(fblank), 0);
        chk("R1 reset reads", int'({rd_main, rd_sub}), 0);
        chk("R1 reset colour", int'({col_o, lvl_o}), 0);
        rst_n = 1'b1;

        // R1: enables set but no field sync yet: everything stays live
        apply(VEC[0]);
        scan(VEC[0], 1, 8, 1'b1);

        // table walk
        for (int i = 0; i < 6; i++) begin
            apply(VEC[i]);
            field_sync();
            sub_seen = 0;
            scan(VEC[i], 1, 24, 1'b0);
            chk($sformatf("R4 sub window area, vector %0d", i), sub_seen, int'(VEC[i].exp_sub));
        end

        // R3: mid-field change has no effect until next field sync
        apply(VEC[0]);
        field_sync();
        scan(VEC[0], 1, 3, 1'b0);
        apply(VEC[2]);
        scan(VEC[0], 4, 24, 1'b0);
        field_sync();
        scan(VEC[2], 1, 24, 1'b0);

        // R9: lost field sync drops to live after the line limit
        apply(HOLD_CFG);
        field_sync();
        scan(HOLD_CFG, 1, T_MAXL + 5, 1'b0);
        // R9: next field sync resumes composition
        apply(VEC[3]);
        field_sync();
        sub_seen = 0;
        scan(VEC[3], 1, 24, 1'b0);
        chk("R9 composition resumed after hold", sub_seen, int'(VEC[3].exp_sub));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule